// File: doc/BRIEF.md
# Pulse-Coupled Gate Command Decoder

This block sits on the primary side of an isolated converter and turns edge strobes that arrive over one isolated coupling path into a gate command for the primary switch. A positive strobe switches the gate on and a negative strobe switches it off. A cycle counter caps every on-interval. The cap is short while the converter is in soft-start and longer once the secondary side has taken over regulation. The gate follows the strobes only after the block has locked, which takes a programmable number of positive strobes seen during start-up.

The same coupling path carries an in-band stop message. A run of negative strobes with no positive strobe between them is decoded as a stop request. The block then holds the gate low, ignores the path, and after a fixed delay counted in timebase ticks it raises its shutdown output. That output stays high until reset.

The control is a five-state machine. The states are ACQUIRE (not yet locked), IDLE_OFF (locked, gate low), DRIVE_ON (gate high), DRAIN (stop decoded, delay running) and HALT (shut down). The transitions are: ACQUIRE→IDLE_OFF on lock; IDLE_OFF→DRIVE_ON on a positive strobe; DRIVE_ON→IDLE_OFF on a negative strobe or when the cap expires; ACQUIRE, IDLE_OFF or DRIVE_ON →DRAIN when the stop run completes; DRAIN→HALT when the delay expires. HALT has no exit except reset.

Top module: `pcg_decoder`

## Requirements
- R1: After reset gate_on, shutdown_req and sync_locked are all low and the block is acquiring.
- R2: sync_locked rises in the cycle after the LOCK_PULSES-th (default 3) positive strobe seen while soft_start is high. Positive strobes taken while soft_start is low do not count. The gate stays low until lock.
- R3: When locked with the gate off, a positive strobe raises gate_on in the next cycle. When the gate is on, a negative strobe lowers it in the next cycle.
- R4: A positive strobe while the gate is on is ignored and does not restart or extend the on-interval.
- R5: A cycle where positive and negative strobes are both high is ignored entirely: it changes neither the gate nor the stop-run count.
- R6: With soft_start high, the gate goes low after SS_ON_NS of clock time (19 cycles at the 1 MHz default) even without a negative strobe.
- R7: With soft_start low, the on-interval cap is RUN_ON_NS (25 cycles at the default clock).
- R8: RUN_LEN (default 3) negative strobes with no positive strobe between them make the block hold gate_on low, drop sync_locked and ignore all strobes. Any positive strobe restarts the count.
- R9: shutdown_req rises once SHUT_MS worth of timebase ticks (200 ticks at the 1 kHz default) have occurred after the stop is decoded. Only cycles with tick high count.
- R10: Once shutdown_req is high it stays high, gate_on stays low and all strobes are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_strobe | input | 1 | Qualified positive edge strobe, one cycle |
| neg_strobe | input | 1 | Qualified negative edge strobe, one cycle |
| soft_start | input | 1 | High while the converter is in soft-start |
| tick | input | 1 | Timebase enable at TICK_HZ for the stop delay |
| gate_on | output | 1 | Primary switch gate command |
| shutdown_req | output | 1 | High once the stop delay has elapsed |
| sync_locked | output | 1 | High while the gate follows the strobes |

## Verification
A wrong state register shows up at the ports one cycle after the strobe that exposed it. A gate that fails to rise or fall shows on gate_on, and a missed or early lock or stop shows on sync_locked. A wrong on-interval counter moves the cap's falling edge away from cycle 19 or 25 after turn-on. A re-armed counter shows as an interval longer than the cap. A stop-run count that is not cleared or is miscounted either drops sync_locked too early or leaves the gate responsive after the third negative strobe. A wrong drain counter moves the rise of shutdown_req off the 200th tick.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    typedef enum logic [2:0] {
        ST_ACQUIRE,
        ST_IDLE_OFF,
        ST_DRIVE_ON,
        ST_DRAIN,
        ST_HALT
    } pcg_state_e;

    // Converts a time in nanoseconds to whole clock cycles.
    function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (hz * ns) / 64'd1000000000;
        return int'(c);
    endfunction

    // Converts a delay in milliseconds to whole timebase ticks.
    function automatic int unsigned ms_to_ticks(longint unsigned tick_hz, longint unsigned ms);
        longint unsigned c;
        c = (tick_hz * ms) / 64'd1000;
        return int'(c);
    endfunction

endpackage

// File: rtl/pcg_lock_qual.sv
module pcg_lock_qual #(
    parameter int LOCK_PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hit,
    output logic lock_done
);
    localparam int W = $clog2(LOCK_PULSES + 1);
    localparam logic [W-1:0] LAST = W'(LOCK_PULSES - 1);

    logic [W-1:0] cnt_q;

    assign lock_done = enable && hit && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (hit && !lock_done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_LOCK_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(LOCK_PULSES)); // R2

endmodule

// File: rtl/pcg_neg_run.sv
module pcg_neg_run #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pos,
    input  logic neg,
    output logic run_done
);
    localparam int W = $clog2(RUN_LEN + 1);
    localparam logic [W-1:0] LAST = W'(RUN_LEN - 1);

    logic [W-1:0] cnt_q;

    assign run_done = enable && neg && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || pos) begin
            cnt_q <= '0;
        end else if (neg && !run_done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RUN_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(RUN_LEN)); // R8
    AST_RUN_CLEARED_BY_POS: assert property (@(posedge clk) disable iff (!rst_n)
        pos |=> cnt_q == '0); // R8

endmodule

// File: rtl/pcg_ontime_timer.sv
module pcg_ontime_timer #(
    parameter int SS_CYC  = 19,
    parameter int RUN_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic soft_start,
    output logic expire
);
    localparam int LIM_MAX = (SS_CYC > RUN_CYC) ? SS_CYC : RUN_CYC;
    localparam int W = $clog2(LIM_MAX + 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] lim;

    assign lim    = soft_start ? W'(SS_CYC) : W'(RUN_CYC);
    assign expire = run && (cnt_q >= lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q < W'(LIM_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_ONTIME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q < W'(LIM_MAX)); // R7
    AST_ONTIME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0); // R6

endmodule

// File: rtl/pcg_drain_timer.sv
module pcg_drain_timer #(
    parameter int TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(TICKS + 1);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    logic [W-1:0] cnt_q;

    assign done = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(TICKS)); // R9
    AST_DRAIN_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/pcg_decoder.sv
module pcg_decoder #(
    parameter int CLK_HZ      = 1000000,
    parameter int SS_ON_NS    = 19000,
    parameter int RUN_ON_NS   = 25000,
    parameter int TICK_HZ     = 1000,
    parameter int SHUT_MS     = 200,
    parameter int LOCK_PULSES = 3,
    parameter int RUN_LEN     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_strobe,
    input  logic neg_strobe,
    input  logic soft_start,
    input  logic tick,
    output logic gate_on,
    output logic shutdown_req,
    output logic sync_locked
);
    import pcg_pkg::*;

    localparam int SS_CYC      = int'(ns_to_cycles(64'(CLK_HZ), 64'(SS_ON_NS)));
    localparam int RUN_CYC     = int'(ns_to_cycles(64'(CLK_HZ), 64'(RUN_ON_NS)));
    localparam int DRAIN_TICKS = int'(ms_to_ticks(64'(TICK_HZ), 64'(SHUT_MS)));

    pcg_state_e state_q, state_d;

    logic pos_q, neg_q;
    logic active, lock_done, run_done, cap_expire, drain_done;

    // A cycle with both polarities is treated as noise and dropped.
    assign pos_q  = pos_strobe && !neg_strobe;
    assign neg_q  = neg_strobe && !pos_strobe;
    assign active = (state_q == ST_ACQUIRE) || (state_q == ST_IDLE_OFF) ||
                    (state_q == ST_DRIVE_ON);

    pcg_lock_qual #(.LOCK_PULSES(LOCK_PULSES)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (state_q == ST_ACQUIRE),
        .hit       (pos_q && soft_start),
        .lock_done (lock_done)
    );

    pcg_neg_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (active),
        .pos      (pos_q),
        .neg      (neg_q),
        .run_done (run_done)
    );

    pcg_ontime_timer #(.SS_CYC(SS_CYC), .RUN_CYC(RUN_CYC)) u_ontime (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state_q == ST_DRIVE_ON),
        .soft_start (soft_start),
        .expire     (cap_expire)
    );

    pcg_drain_timer #(.TICKS(DRAIN_TICKS)) u_drain (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_DRAIN),
        .tick  (tick),
        .done  (drain_done)
    );

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (run_done)       state_d = ST_DRAIN;
                else if (lock_done) state_d = ST_IDLE_OFF;
            end
            ST_IDLE_OFF: begin
                if (run_done)   state_d = ST_DRAIN;
                else if (pos_q) state_d = ST_DRIVE_ON;
            end
            ST_DRIVE_ON: begin
                if (run_done)                 state_d = ST_DRAIN;
                else if (neg_q || cap_expire) state_d = ST_IDLE_OFF;
            end
            ST_DRAIN: begin
                if (drain_done) state_d = ST_HALT;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACQUIRE;
        else        state_q <= state_d;
    end

    // Moore outputs.
    always_comb begin
        gate_on      = 1'b0;
        shutdown_req = 1'b0;
        sync_locked  = 1'b0;
        unique case (state_q)
            ST_ACQUIRE:  ;
            ST_IDLE_OFF: sync_locked = 1'b1;
            ST_DRIVE_ON: begin
                sync_locked = 1'b1;
                gate_on     = 1'b1;
            end
            ST_DRAIN:    ;
            ST_HALT:     shutdown_req = 1'b1;
            default:     ;
        endcase
    end

    AST_GATE_RISE_ON_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> $past(pos_strobe && !neg_strobe)); // R3
    AST_GATE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> $past(sync_locked)); // R2
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> (shutdown_req && !gate_on && !sync_locked)); // R10
    AST_HALT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(tick)); // R9
    AST_BOTH_STROBES_HOLD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_strobe && neg_strobe && !gate_on) |=> !gate_on); // R5

endmodule

// File: tb/test_pcg_decoder.sv
module test_pcg_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_strobe = 1'b0;
    logic neg_strobe = 1'b0;
    logic soft_start = 1'b1;
    logic tick = 1'b0;
    logic gate_on, shutdown_req, sync_locked;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcg_decoder i_pcg_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .pos_strobe   (pos_strobe),
        .neg_strobe   (neg_strobe),
        .soft_start   (soft_start),
        .tick         (tick),
        .gate_on      (gate_on),
        .shutdown_req (shutdown_req),
        .sync_locked  (sync_locked)
    );

    // Row fields: {pos, neg, soft_start, expected gate, expected lock}
    localparam logic [4:0] VEC [0:N_VEC-1] = '{
        5'b10100, // R2 first counted pulse, no gate
        5'b00100,
        5'b10100, // R2 second counted pulse
        5'b10000, // R2 soft_start low: not counted
        5'b10101, // R2 third counted pulse: lock
        5'b00101,
        5'b10111, // R3 turn on
        5'b00111,
        5'b10111, // R4 ignored while on
        5'b01101, // R3 turn off, run count 1
        5'b11101, // R5 both high ignored
        5'b01101, // R8 run count 2
        5'b10111, // R8 positive clears run, turn on
        5'b01101, // run count 1
        5'b01101, // run count 2
        5'b00101,
        5'b10111  // R8 still responsive after interrupted run
    };

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge; presents inputs for one rising edge.
    task automatic drive(logic p, logic n, logic s);
        pos_strobe = p;
        neg_strobe = n;
        soft_start = s;
        @(negedge clk);
        pos_strobe = 1'b0;
        neg_strobe = 1'b0;
    endtask

    task automatic idle(int k, logic s);
        for (int i = 0; i < k; i++) drive(1'b0, 1'b0, s);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_lock();
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b1);
        check("R2", "lock after three", sync_locked, 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        check("R1", "gate", gate_on, 1'b0);
        check("R1", "shutdown", shutdown_req, 1'b0);
        check("R1", "lock", sync_locked, 1'b0);

        for (int v = 0; v < N_VEC; v++) begin
            drive(VEC[v][4], VEC[v][3], VEC[v][2]);
            check($sformatf("R3 row %0d", v), "gate", gate_on, VEC[v][1]);
            check($sformatf("R2 row %0d", v), "lock", sync_locked, VEC[v][0]);
        end

        // R6: soft-start cap of 19 cycles
        do_reset();
        do_lock();
        drive(1'b1, 1'b0, 1'b1);
        idle(18, 1'b1);
        check("R6", "gate before cap", gate_on, 1'b1);
        idle(1, 1'b1);
        check("R6", "gate at cap", gate_on, 1'b0);

        // R7: run cap of 25 cycles
        drive(1'b1, 1'b0, 1'b0);
        idle(24, 1'b0);
        check("R7", "gate before cap", gate_on, 1'b1);
        idle(1, 1'b0);
        check("R7", "gate at cap", gate_on, 1'b0);

        // R4: retrigger does not extend
        drive(1'b1, 1'b0, 1'b1);
        idle(9, 1'b1);
        drive(1'b1, 1'b0, 1'b1);
        idle(8, 1'b1);
        check("R4", "gate before cap", gate_on, 1'b1);
        idle(1, 1'b1);
        check("R4", "gate at original cap", gate_on, 1'b0);

        // R5: both strobes with gate off do not turn it on
        drive(1'b1, 1'b1, 1'b1);
        check("R5", "gate", gate_on, 1'b0);

        // R8, R9, R10: stop run, delay, halt
        do_reset();
        do_lock();
        drive(1'b1, 1'b0, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        drive(1'b0, 1'b1, 1'b1);
        check("R8", "lock after run", sync_locked, 1'b0);
        check("R8", "shutdown not yet", shutdown_req, 1'b0);
        drive(1'b1, 1'b0, 1'b1);
        check("R8", "gate ignores pos", gate_on, 1'b0);
        idle(49, 1'b1);
        check("R9", "no ticks, no halt", shutdown_req, 1'b0);
        tick = 1'b1;
        idle(199, 1'b1);
        check("R9", "before last tick", shutdown_req, 1'b0);
        idle(1, 1'b1);
        check("R9", "halt at tick 200", shutdown_req, 1'b1);
        drive(1'b1, 1'b0, 1'b1);
        check("R10", "gate stays low", gate_on, 1'b0);
        idle(3, 1'b0);
        check("R10", "shutdown sticky", shutdown_req, 1'b1);
        check("R10", "lock stays low", sync_locked, 1'b0);

        // R1: reset releases halt
        do_reset();
        check("R1", "shutdown cleared", shutdown_req, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule